// File: doc/BRIEF.md
# Flash Write-Protect Range Controller

This block holds the protection configuration of an 8 MiB serial NOR flash and decides, for every program or erase request, whether the addressed bytes may be touched. An eight-bit configuration word is loaded through a simple write port. From that word the block decodes a protected window, given as a start address and a length. The window can be a fine 4 to 32 KiB window, a coarse binary fraction of the array, the whole array, or the complement of any of these. The block also reports which protection mode is active.

An active-low guard input works together with the lock bit of the configuration word. While the lock bit is set and the guard input is driven low, no configuration write is accepted. The decoded window, the mode and the configuration readback are all registered. A request port takes an address and an access kind. One cycle later it returns an allow or a block, and a blocked request also raises a one-cycle error pulse.

Top module: `wp_range_ctrl`

## Requirements
- R1: After reset the configuration readback is 0x00, the window start is 0, the window length is 0, the mode is 0 (disabled) and no check result is valid.
- R2: The configuration word has this layout: bit 7 lock_perm, bit 6 lock_en, bit 5 invert, bit 4 fine, bit 3 bottom, bits 2:0 size. An accepted write appears on the readback, window and mode outputs at the clock edge that samples it.
- R3: With fine=0 and invert=0, size 0 protects nothing. Sizes 1 to 6 protect 1/64, 1/32, 1/16, 1/8, 1/4 and 1/2 of the array, and size 7 protects all of it. A top window (bottom=0) ends at 0x7FFFFF; for example, size 5 gives start 0x600000 and length 0x200000.
- R4: With fine=1 and invert=0, size 0 protects nothing. Sizes 1, 2 and 3 protect 4, 8 and 16 KiB, and sizes 4 to 7 protect 32 KiB. For example, a top window of size 3 gives start 0x7FC000 and length 0x4000.
- R5: bottom=1 places the window at address 0 instead of at the top of the array.
- R6: invert=1 protects exactly the addresses the same setting would leave open with invert=0. An empty window becomes the whole array and a whole-array window becomes empty. For example, fine top size 3 inverted gives start 0 and length 0x7FC000.
- R7: While lock_en=1 and the guard input is low, every configuration write is ignored, and the stored word and the decoded window stay unchanged.
- R8: With the guard input high, a locked word can be rewritten. A write that clears lock_en and keeps the range bits shows mode 0 with the old window still in place.
- R9: The mode output is 0 (disabled) when lock_en=0, 1 (hardware) when lock_en=1 and lock_perm=0, and 2 when both are 1.
- R10: Access kind encoding: 0 = single-byte program, 1 = 4 KiB sector erase, 2 = 64 KiB block erase, 3 = whole-chip erase. A request is blocked when any byte of its aligned extent falls inside the window, and allowed otherwise. The result is valid exactly one cycle after the request.
- R11: A blocked request raises the error output for exactly the one cycle in which its result is valid. An allowed request never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration word to write |
| guard_n | input | 1 | Active-low hardware guard; with lock_en set, it freezes the configuration |
| cfg_rd | output | 8 | Stored configuration word |
| prot_start | output | 23 | First protected address |
| prot_len | output | 24 | Protected length in bytes (0 = none) |
| prot_mode | output | 2 | 0 disabled, 1 hardware, 2 permanent-style |
| chk_req | input | 1 | Access check request |
| chk_kind | input | 2 | Access kind (R10 encoding) |
| chk_addr | input | 23 | Byte address of the access |
| chk_valid | output | 1 | Check result valid |
| chk_allow | output | 1 | Access may proceed |
| chk_err | output | 1 | One-cycle pulse for a blocked access |

## Verification
The bench sweeps every size code in both granularities, both placements and both polarities. A decoder with an off-by-one fraction table would shift every window by a factor of two. Getting the complement wrong would show at the two degenerate codes, none and all, where an inverted window must become full or empty rather than wrap. Access checks probe the byte just below and just at the window start, and erases whose aligned extent reaches into the window from an unprotected address. A checker that compared the raw address instead of the aligned extent would allow those erases. The lock sequence writes while the guard is low, then writes again after releasing it: a lock tied only to the bit, or only to the pin, would either accept the first write or refuse the second.

// File: rtl/wp_pkg.sv
package wp_pkg;

    // Configuration word as stored; bit order is the software-visible layout.
    typedef struct packed {
        logic       perm;    // bit 7
        logic       lock;    // bit 6
        logic       inv;     // bit 5
        logic       fine;    // bit 4
        logic       bottom;  // bit 3
        logic [2:0] size;    // bits 2:0
    } wp_cfg_t;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_HW   = 2'd1,
        MODE_PERM = 2'd2
    } wp_mode_e;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_SECT = 2'd1,
        ACC_BLK  = 2'd2,
        ACC_CHIP = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/wp_cfg_reg.sv
module wp_cfg_reg
    import wp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    input  logic       guard_n,
    output wp_cfg_t    cfg_cur,
    output wp_cfg_t    cfg_nxt
);

    wp_cfg_t cfg_d, cfg_q;
    logic    frozen;

    always_comb begin
        frozen = cfg_q.lock && !guard_n;
        cfg_d  = cfg_q;
        if (wr_en && !frozen) begin
            cfg_d = wp_cfg_t'(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_cur = cfg_q;
    assign cfg_nxt = cfg_d;

endmodule

// File: rtl/wp_range_decode.sv
module wp_range_decode
    import wp_pkg::*;
#(
    parameter int ADDR_W     = 23,
    parameter int FINE_SHIFT = 12
) (
    input  wp_cfg_t           cfg,
    output logic [ADDR_W-1:0] start,
    output logic [ADDR_W:0]   len,
    output logic [1:0]        mode
);

    localparam int LEN_W = ADDR_W + 1;
    localparam logic [LEN_W-1:0] TOTAL    = LEN_W'(1) << ADDR_W;
    localparam int               FINE_MAX = 4;   // size codes at or above this saturate

    logic [LEN_W-1:0] base_len;
    wp_mode_e         mode_v;

    // Size code to window length before placement and inversion.
    always_comb begin
        base_len = '0;
        if (cfg.size != 3'd0) begin
            if (cfg.fine) begin
                if (int'(cfg.size) >= FINE_MAX) begin
                    base_len = LEN_W'(1) << (FINE_SHIFT + FINE_MAX - 1);
                end else begin
                    base_len = LEN_W'(1) << (FINE_SHIFT + int'(cfg.size) - 1);
                end
            end else if (cfg.size == 3'd7) begin
                base_len = TOTAL;
            end else begin
                base_len = TOTAL >> (7 - int'(cfg.size));
            end
        end
    end

    // Placement and complement.
    always_comb begin
        if (!cfg.inv) begin
            len = base_len;
            if (cfg.bottom || base_len == '0) begin
                start = '0;
            end else begin
                start = ADDR_W'(TOTAL - base_len);
            end
        end else begin
            len = TOTAL - base_len;
            if (cfg.bottom && base_len != TOTAL) begin
                start = ADDR_W'(base_len);
            end else begin
                start = '0;
            end
        end
    end

    always_comb begin
        if (!cfg.lock) begin
            mode_v = MODE_OFF;
        end else if (!cfg.perm) begin
            mode_v = MODE_HW;
        end else begin
            mode_v = MODE_PERM;
        end
        mode = mode_v;
    end

endmodule

// File: rtl/wp_access_check.sv
module wp_access_check
    import wp_pkg::*;
#(
    parameter int ADDR_W     = 23,
    parameter int FINE_SHIFT = 12,
    parameter int BLK_SHIFT  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [1:0]        kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] prot_start,
    input  logic [ADDR_W:0]   prot_len,
    output logic              valid,
    output logic              allow,
    output logic              err
);

    localparam int LEN_W = ADDR_W + 1;
    localparam logic [ADDR_W-1:0] SECT_MASK = ADDR_W'((64'd1 << FINE_SHIFT) - 64'd1);
    localparam logic [ADDR_W-1:0] BLK_MASK  = ADDR_W'((64'd1 << BLK_SHIFT) - 64'd1);

    typedef struct packed {
        logic valid;
        logic allow;
        logic err;
    } res_t;

    res_t             res_d, res_q;
    logic [ADDR_W-1:0] lo, hi;
    logic [LEN_W-1:0]  prot_last;
    logic              overlap;

    always_comb begin
        unique case (acc_kind_e'(kind))
            ACC_BYTE: begin
                lo = addr;
                hi = addr;
            end
            ACC_SECT: begin
                lo = addr & ~SECT_MASK;
                hi = addr | SECT_MASK;
            end
            ACC_BLK: begin
                lo = addr & ~BLK_MASK;
                hi = addr | BLK_MASK;
            end
            default: begin
                lo = '0;
                hi = '1;
            end
        endcase

        prot_last = {1'b0, prot_start} + prot_len - LEN_W'(1);
        overlap   = (prot_len != '0)
                 && ({1'b0, hi} >= {1'b0, prot_start})
                 && ({1'b0, lo} <= prot_last);

        res_d.valid = req;
        res_d.allow = req && !overlap;
        res_d.err   = req && overlap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign valid = res_q.valid;
    assign allow = res_q.allow;
    assign err   = res_q.err;

endmodule

// File: rtl/wp_range_ctrl.sv
module wp_range_ctrl
    import wp_pkg::*;
#(
    parameter int ADDR_W     = 23,
    parameter int FINE_SHIFT = 12,
    parameter int BLK_SHIFT  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_wdata,
    input  logic              guard_n,
    output logic [7:0]        cfg_rd,
    output logic [ADDR_W-1:0] prot_start,
    output logic [ADDR_W:0]   prot_len,
    output logic [1:0]        prot_mode,
    input  logic              chk_req,
    input  logic [1:0]        chk_kind,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic              chk_valid,
    output logic              chk_allow,
    output logic              chk_err
);

    typedef struct packed {
        logic [ADDR_W-1:0] start;
        logic [ADDR_W:0]   len;
        logic [1:0]        mode;
    } win_t;

    wp_cfg_t cfg_cur, cfg_nxt;
    win_t    win_d, win_q;
    logic [ADDR_W-1:0] dec_start;
    logic [ADDR_W:0]   dec_len;
    logic [1:0]        dec_mode;

    wp_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wdata   (cfg_wdata),
        .guard_n (guard_n),
        .cfg_cur (cfg_cur),
        .cfg_nxt (cfg_nxt)
    );

    // Decode the word being stored so the window lands with the word itself.
    wp_range_decode #(
        .ADDR_W     (ADDR_W),
        .FINE_SHIFT (FINE_SHIFT)
    ) u_dec (
        .cfg   (cfg_nxt),
        .start (dec_start),
        .len   (dec_len),
        .mode  (dec_mode)
    );

    always_comb begin
        win_d.start = dec_start;
        win_d.len   = dec_len;
        win_d.mode  = dec_mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    wp_access_check #(
        .ADDR_W     (ADDR_W),
        .FINE_SHIFT (FINE_SHIFT),
        .BLK_SHIFT  (BLK_SHIFT)
    ) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (chk_req),
        .kind       (chk_kind),
        .addr       (chk_addr),
        .prot_start (win_q.start),
        .prot_len   (win_q.len),
        .valid      (chk_valid),
        .allow      (chk_allow),
        .err        (chk_err)
    );

    assign cfg_rd     = cfg_cur;
    assign prot_start = win_q.start;
    assign prot_len   = win_q.len;
    assign prot_mode  = win_q.mode;

endmodule

// File: rtl/wp_range_ctrl_chk.sv
module wp_range_ctrl_chk #(
    parameter int ADDR_W     = 23,
    parameter int FINE_SHIFT = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [7:0]        cfg_wdata,
    input logic              guard_n,
    input logic [7:0]        cfg_rd,
    input logic [ADDR_W-1:0] prot_start,
    input logic [ADDR_W:0]   prot_len,
    input logic [1:0]        prot_mode,
    input logic              chk_req,
    input logic              chk_valid,
    input logic              chk_allow,
    input logic              chk_err
);

    localparam logic [ADDR_W+1:0] TOTAL    = (ADDR_W+2)'(1) << ADDR_W;
    localparam logic [ADDR_W:0]   FINE_TOP = (ADDR_W+1)'(1) << (FINE_SHIFT + 3);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd == 8'h00 |-> prot_len == '0 && prot_mode == 2'd0);

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && !(cfg_rd[6] && !guard_n) |=> cfg_rd == $past(cfg_wdata));

    assert_window_in_array_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, {1'b0, prot_start}} + {1'b0, prot_len}) <= TOTAL);

    assert_fine_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd[4] && !cfg_rd[5] |-> prot_len <= FINE_TOP);

    assert_locked_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && cfg_rd[6] && !guard_n |=> $stable(cfg_rd) && $stable(prot_len));

    assert_mode_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd[6] |-> prot_mode == 2'd0);

    assert_mode_hw_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd[6] && !cfg_rd[7] |-> prot_mode == 2'd1);

    assert_result_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
        chk_req |=> chk_valid);

    assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_req |=> !chk_valid);

    assert_err_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |-> (chk_allow != chk_err));

    assert_err_only_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |-> !chk_err && !chk_allow);

endmodule

bind wp_range_ctrl wp_range_ctrl_chk #(
    .ADDR_W     (ADDR_W),
    .FINE_SHIFT (FINE_SHIFT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .guard_n    (guard_n),
    .cfg_rd     (cfg_rd),
    .prot_start (prot_start),
    .prot_len   (prot_len),
    .prot_mode  (prot_mode),
    .chk_req    (chk_req),
    .chk_valid  (chk_valid),
    .chk_allow  (chk_allow),
    .chk_err    (chk_err)
);

// File: tb/sim_wp_range_ctrl.sv
`timescale 1ns/1ps
module sim_wp_range_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic        guard_n = 1'b1;
    logic [7:0]  cfg_rd;
    logic [22:0] prot_start;
    logic [23:0] prot_len;
    logic [1:0]  prot_mode;
    logic        chk_req = 1'b0;
    logic [1:0]  chk_kind = '0;
    logic [22:0] chk_addr = '0;
    logic        chk_valid, chk_allow, chk_err;

    always #10 clk = ~clk;

    wp_range_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .guard_n(guard_n), .cfg_rd(cfg_rd), .prot_start(prot_start),
        .prot_len(prot_len), .prot_mode(prot_mode), .chk_req(chk_req),
        .chk_kind(chk_kind), .chk_addr(chk_addr), .chk_valid(chk_valid),
        .chk_allow(chk_allow), .chk_err(chk_err)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Scoreboard queues
    logic [7:0]  q_cfg[$];
    logic [22:0] q_st[$];
    logic [23:0] q_ln[$];
    logic [1:0]  q_md[$];
    string       q_ctag[$];
    logic        q_allow[$];
    string       q_atag[$];

    logic [7:0]  exp_cfg = 8'h00;
    logic        cfg_seen = 1'b0;
    logic        last_blk = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // Independent model of the requirements
    task automatic model(input logic [7:0] c, output logic [22:0] st,
                         output logic [23:0] ln, output logic [1:0] md);
        logic [23:0] b;
        if (c[4]) begin
            case (c[2:0])
                3'd0: b = 24'h000000;
                3'd1: b = 24'h001000;
                3'd2: b = 24'h002000;
                3'd3: b = 24'h004000;
                default: b = 24'h008000;
            endcase
        end else begin
            case (c[2:0])
                3'd0: b = 24'h000000;
                3'd1: b = 24'h020000;
                3'd2: b = 24'h040000;
                3'd3: b = 24'h080000;
                3'd4: b = 24'h100000;
                3'd5: b = 24'h200000;
                3'd6: b = 24'h400000;
                default: b = 24'h800000;
            endcase
        end
        if (!c[5]) begin
            ln = b;
            st = (c[3] || b == 0) ? 23'h0 : 23'(24'h800000 - b);
        end else begin
            ln = 24'h800000 - b;
            st = (c[3] && b != 24'h800000) ? 23'(b) : 23'h0;
        end
        md = !c[6] ? 2'd0 : (!c[7] ? 2'd1 : 2'd2);
    endtask

    task automatic wr_cfg(input logic [7:0] d, input string tag);
        logic [22:0] s; logic [23:0] l; logic [1:0] m;
        if (!(exp_cfg[6] && !guard_n)) exp_cfg = d;
        model(exp_cfg, s, l, m);
        q_cfg.push_back(exp_cfg); q_st.push_back(s); q_ln.push_back(l);
        q_md.push_back(m); q_ctag.push_back(tag);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = d;
        @(negedge clk); cfg_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_chk(input logic [1:0] k, input logic [22:0] a, input string tag);
        logic [22:0] s; logic [23:0] l; logic [1:0] m;
        int lo, hi;
        bit blk;
        model(exp_cfg, s, l, m);
        case (k)
            2'd0: begin lo = int'(a); hi = int'(a); end
            2'd1: begin lo = int'(a) / 4096 * 4096; hi = lo + 4095; end
            2'd2: begin lo = int'(a) / 65536 * 65536; hi = lo + 65535; end
            default: begin lo = 0; hi = 32'h7FFFFF; end
        endcase
        blk = (l != 0) && (hi >= int'(s)) && (lo <= int'(s) + int'(l) - 1);
        q_allow.push_back(!blk); q_atag.push_back(tag);
        @(negedge clk); chk_req = 1'b1; chk_kind = k; chk_addr = a;
        @(negedge clk); chk_req = 1'b0;
        @(negedge clk);
    endtask

    always @(posedge clk) cfg_seen <= cfg_wr;

    // Monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (cfg_seen) begin
                if (q_cfg.size() == 0) begin
                    check(1'b0, "R2", "unexpected config update", 32'(cfg_rd), 32'h0);
                end else begin
                    logic [7:0] ec; logic [22:0] es; logic [23:0] el; logic [1:0] em; string t;
                    ec = q_cfg.pop_front(); es = q_st.pop_front(); el = q_ln.pop_front();
                    em = q_md.pop_front(); t = q_ctag.pop_front();
                    check(cfg_rd == ec, t, "cfg_rd", 32'(cfg_rd), 32'(ec));
                    check(prot_start == es, t, "prot_start", 32'(prot_start), 32'(es));
                    check(prot_len == el, t, "prot_len", 32'(prot_len), 32'(el));
                    check(prot_mode == em, t, "prot_mode (R9)", 32'(prot_mode), 32'(em));
                end
            end
            if (chk_valid) begin
                if (q_allow.size() == 0) begin
                    check(1'b0, "R10", "unexpected result", 32'(chk_valid), 32'h0);
                end else begin
                    logic ea; string t;
                    ea = q_allow.pop_front(); t = q_atag.pop_front();
                    check(chk_allow == ea, t, "chk_allow", 32'(chk_allow), 32'(ea));
                    check(chk_err == !ea, {t, "/R11"}, "chk_err", 32'(chk_err), 32'(!ea));
                    last_blk = !ea;
                end
            end else if (last_blk) begin
                check(chk_err == 1'b0, "R11", "err pulse longer than one cycle",
                      32'(chk_err), 32'h0);
                last_blk = 1'b0;
            end
        end
    end

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R10 watchdog expired: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cfg_rd == 8'h00, "R1", "cfg_rd", 32'(cfg_rd), 32'h0);
        check(prot_start == 0, "R1", "prot_start", 32'(prot_start), 32'h0);
        check(prot_len == 0, "R1", "prot_len", 32'(prot_len), 32'h0);
        check(prot_mode == 0, "R1", "prot_mode", 32'(prot_mode), 32'h0);
        check(chk_valid == 0, "R1", "chk_valid", 32'(chk_valid), 32'h0);

        wr_cfg(8'h13, "R2");                                   // fine top 16 KiB
        for (int b = 0; b < 8; b++) wr_cfg(8'(b), "R3");       // coarse top
        for (int b = 0; b < 8; b++) wr_cfg(8'h08 | 8'(b), "R5"); // coarse bottom
        for (int b = 0; b < 8; b++) wr_cfg(8'h10 | 8'(b), "R4"); // fine top
        for (int b = 0; b < 8; b++) wr_cfg(8'h18 | 8'(b), "R5"); // fine bottom
        for (int b = 0; b < 8; b++) wr_cfg(8'h20 | 8'(b), "R6"); // inverted coarse top
        for (int b = 0; b < 8; b++) wr_cfg(8'h28 | 8'(b), "R6"); // inverted coarse bottom
        wr_cfg(8'h33, "R6");                                   // lower 511/512
        wr_cfg(8'h3F, "R6");

        // R10 access checks against top 16 KiB
        wr_cfg(8'h13, "R4");
        do_chk(2'd0, 23'h7FBFFF, "R10");
        do_chk(2'd0, 23'h7FC000, "R10");
        do_chk(2'd0, 23'h7FFFFF, "R10");
        do_chk(2'd1, 23'h7FBABC, "R10");
        do_chk(2'd2, 23'h7F1234, "R10");
        do_chk(2'd3, 23'h000000, "R10");
        do_chk(2'd0, 23'h000000, "R10");
        // bottom quarter
        wr_cfg(8'h0D, "R5");
        do_chk(2'd0, 23'h1FFFFF, "R10");
        do_chk(2'd0, 23'h200000, "R10");
        do_chk(2'd1, 23'h200FFF, "R10");
        do_chk(2'd2, 23'h1F0001, "R10");
        // complement
        wr_cfg(8'h33, "R6");
        do_chk(2'd0, 23'h7FC000, "R10");
        do_chk(2'd0, 23'h7FBFFF, "R10");
        wr_cfg(8'h00, "R1");
        do_chk(2'd3, 23'h123456, "R10");

        // Lock sequence
        wr_cfg(8'h53, "R9");
        guard_n = 1'b0;
        wr_cfg(8'h00, "R7");
        wr_cfg(8'h7F, "R7");
        do_chk(2'd0, 23'h7FC000, "R7");
        guard_n = 1'b1;
        wr_cfg(8'h13, "R8");
        do_chk(2'd0, 23'h7FC000, "R8");
        wr_cfg(8'hD3, "R9");
        guard_n = 1'b0;
        wr_cfg(8'h13, "R7");
        guard_n = 1'b1;
        wr_cfg(8'h00, "R8");

        repeat (4) @(negedge clk);
        check(q_cfg.size() == 0 && q_allow.size() == 0, "R10", "scoreboard drained",
              32'(q_cfg.size() + q_allow.size()), 32'h0);
        summary();
        $finish;
    end

endmodule